// File: doc/BRIEF.md
# Bus-Slave Four-Phase Handshake Controller

This controller sits between a parallel bus master and a local device. The master requests a transfer by raising a read strobe or a write strobe. The controller then runs a four-phase handshake with the device through a device strobe and a device acknowledge. It also drives the enable of a data transceiver, and it answers the master with a bus acknowledge. All decisions are taken on a clock. Each of the three asynchronous inputs first passes through a synchronizer chain of `SYNC_STAGES` flops, two by default.

The two cycle kinds drive the transceiver enable at different points. In a read, the device is strobed first, and the transceiver opens only once the device has answered. In a write, the transceiver opens before the device is strobed, and it closes as soon as the device acknowledges, before the bus sees its acknowledge.

Some points of a cycle show the same levels on every external signal but must lead to different next steps. An internal phase bit is set when a cycle hands back to idle, and it is cleared once the device acknowledge has dropped. A new device strobe can therefore never start while the previous acknowledge is still high. If both strobes are seen high together in idle, the controller starts no cycle and raises a protocol error flag.

Top module: `bus_hs_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, `dev_strobe`, `xcvr_en`, `bus_ack` and `proto_err` are 0 after that edge, and the controller is idle with its phase bit cleared.
- R2: In idle, with `dev_ack` low and the phase bit clear, a rise of `rd_strobe` alone raises `dev_strobe` on the third clock edge after the input change. `xcvr_en` and `bus_ack` stay 0.
- R3: In a read, the rise of `dev_ack` raises `xcvr_en` on the third edge, and `bus_ack` rises one edge later.
- R4: In a read, the fall of `rd_strobe` lowers `xcvr_en` on the third edge. `dev_strobe` and `bus_ack` fall together one edge later.
- R5: In idle, a rise of `wr_strobe` alone raises `xcvr_en` on the third edge, and `dev_strobe` rises one edge later.
- R6: In a write, the rise of `dev_ack` lowers `xcvr_en` on the third edge, and `bus_ack` rises one edge later.
- R7: In a write, the fall of `wr_strobe` lowers `dev_strobe` and `bus_ack` together on the third edge.
- R8: After a cycle ends, no new cycle starts while `dev_ack` is still high. Once `dev_ack` falls, the phase bit clears on the third edge, and a pending strobe starts its cycle one edge after that.
- R9: If both strobes are high in idle, no output other than `proto_err` rises, and `proto_err` is 1 from the third edge on. When one strobe drops, `proto_err` returns to 0 on the third edge.
- R10: A raised `dev_strobe` is never withdrawn before `dev_ack` arrives. A strobe that drops early is ignored until the device has acknowledged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_strobe | input | 1 | Bus read request (asynchronous) |
| wr_strobe | input | 1 | Bus write request (asynchronous) |
| dev_ack | input | 1 | Device acknowledge (asynchronous) |
| dev_strobe | output | 1 | Strobe to the local device |
| xcvr_en | output | 1 | Data transceiver enable |
| bus_ack | output | 1 | Acknowledge to the bus master |
| proto_err | output | 1 | Both strobes seen high in idle |

## Verification
The hardest situation to reach is a new request that arrives while the device acknowledge of the previous cycle is still high. At the ports this looks exactly like a fresh idle, and only the hidden phase bit tells the two apart. The bench completes a read and keeps `dev_ack` high. It then raises the read strobe again, checks that nothing moves for several cycles, and drops `dev_ack`. It then checks that the phase bit clears on the third edge and that the new strobe starts one edge later. The early-release case is also hard to reach: the master withdraws its strobe while the device strobe is still waiting. The bench drops the strobe before it raises `dev_ack`.

// File: rtl/bus_hs_ctrl.sv
module bus_hs_ctrl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_strobe,
  input  logic wr_strobe,
  input  logic dev_ack,
  output logic dev_strobe,
  output logic xcvr_en,
  output logic bus_ack,
  output logic proto_err
);

  typedef enum logic [3:0] {
    S_IDLE, S_RD_REQ, S_RD_DRV, S_RD_ACK, S_RD_DONE,
    S_WR_DRV, S_WR_REQ, S_WR_REL, S_WR_ACK
  } state_t;

  state_t st;
  logic   phase;
  logic [SYNC_STAGES-1:0] rd_q, wr_q, ack_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      ack_q <= '0;
    end else begin
      rd_q  <= {rd_q[SYNC_STAGES-2:0], rd_strobe};
      wr_q  <= {wr_q[SYNC_STAGES-2:0], wr_strobe};
      ack_q <= {ack_q[SYNC_STAGES-2:0], dev_ack};
    end
  end

  wire rd_s  = rd_q[SYNC_STAGES-1];
  wire wr_s  = wr_q[SYNC_STAGES-1];
  wire ack_s = ack_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      phase      <= 1'b0;
      dev_strobe <= 1'b0;
      xcvr_en    <= 1'b0;
      bus_ack    <= 1'b0;
      proto_err  <= 1'b0;
    end else begin
      proto_err <= 1'b0;
      case (st)
        S_IDLE: begin
          proto_err <= rd_s & wr_s;
          if (phase) begin
            if (!ack_s) phase <= 1'b0;
          end else if (!ack_s && !bus_ack) begin
            if (rd_s && !wr_s) begin
              dev_strobe <= 1'b1;
              st         <= S_RD_REQ;
            end else if (wr_s && !rd_s) begin
              xcvr_en <= 1'b1;
              st      <= S_WR_DRV;
            end
          end
        end
        S_RD_REQ: if (ack_s) begin
          xcvr_en <= 1'b1;
          st      <= S_RD_DRV;
        end
        S_RD_DRV: begin
          bus_ack <= 1'b1;
          st      <= S_RD_ACK;
        end
        S_RD_ACK: if (!rd_s) begin
          xcvr_en <= 1'b0;
          st      <= S_RD_DONE;
        end
        S_RD_DONE: begin
          dev_strobe <= 1'b0;
          bus_ack    <= 1'b0;
          phase      <= 1'b1;
          st         <= S_IDLE;
        end
        S_WR_DRV: begin
          dev_strobe <= 1'b1;
          st         <= S_WR_REQ;
        end
        S_WR_REQ: if (ack_s) begin
          xcvr_en <= 1'b0;
          st      <= S_WR_REL;
        end
        S_WR_REL: begin
          bus_ack <= 1'b1;
          st      <= S_WR_ACK;
        end
        S_WR_ACK: if (!wr_s) begin
          dev_strobe <= 1'b0;
          bus_ack    <= 1'b0;
          phase      <= 1'b1;
          st         <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (!dev_strobe && !xcvr_en && !bus_ack && !proto_err)); // R1
  AST_STROBE_AFTER_ACK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_strobe) |-> !$past(ack_s)); // R8
  AST_BUS_ACK_NEEDS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_ack) |-> $past(ack_s)); // R3
  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dev_strobe) |-> $fell(bus_ack)); // R7
  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (!dev_strobe && !xcvr_en && !bus_ack)); // R9
  AST_NO_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(dev_strobe) && !$past(ack_s)) |-> dev_strobe); // R10

endmodule

// File: tb/bus_hs_ctrl_bench.sv
module bus_hs_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic lds, den, dtk, err;
  int   n_run = 0, n_fail = 0;
  bit   done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hs_ctrl u_bus_hs_ctrl (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd), .wr_strobe(wr), .dev_ack(ack),
    .dev_strobe(lds), .xcvr_en(den), .bus_ack(dtk), .proto_err(err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // expected vector order: {dev_strobe, xcvr_en, bus_ack, proto_err}
  task automatic chk(input string req, input logic [3:0] exp);
    n_run++;
    if ({lds, den, dtk, err} !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, {lds, den, dtk, err}, exp);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; rd = 0; wr = 0; ack = 0;
    step(4);
    chk("R1", 4'b0000);
    rst_n = 1'b1;
    step(2);
    chk("R1", 4'b0000);
  endtask

  task automatic t_read();
    rd = 1; step(2); chk("R2", 4'b0000);
    step(1); chk("R2", 4'b1000);
    ack = 1; step(3); chk("R3", 4'b1100);
    step(1); chk("R3", 4'b1110);
    rd = 0; step(3); chk("R4", 4'b1010);
    step(1); chk("R4", 4'b0000);
    ack = 0; step(4);
  endtask

  task automatic t_write();
    wr = 1; step(3); chk("R5", 4'b0100);
    step(1); chk("R5", 4'b1100);
    ack = 1; step(3); chk("R6", 4'b1000);
    step(1); chk("R6", 4'b1010);
    wr = 0; step(2); chk("R7", 4'b1010);
    step(1); chk("R7", 4'b0000);
    ack = 0; step(4);
  endtask

  task automatic t_interlock();
    rd = 1; step(3); ack = 1; step(4);
    rd = 0; step(4); chk("R8", 4'b0000);
    rd = 1; step(8); chk("R8", 4'b0000);
    ack = 0; step(3); chk("R8", 4'b0000);
    step(1); chk("R8", 4'b1000);
    ack = 1; step(4); rd = 0; step(4); ack = 0; step(4);
    chk("R8", 4'b0000);
  endtask

  task automatic t_conflict();
    rd = 1; wr = 1; step(3); chk("R9", 4'b0001);
    step(6); chk("R9", 4'b0001);
    wr = 0; step(3); chk("R9", 4'b1000);
    ack = 1; step(4); rd = 0; step(4); ack = 0; step(4);
    chk("R9", 4'b0000);
  endtask

  task automatic t_early();
    wr = 1; step(4); chk("R10", 4'b1100);
    wr = 0; step(8); chk("R10", 4'b1100);
    ack = 1; step(4); chk("R10", 4'b1010);
    step(3); chk("R10", 4'b0000);
    ack = 0; step(4);
  endtask

  task automatic t_reset_mid();
    rd = 1; step(3); ack = 1; step(4);
    chk("R1", 4'b1110);
    rst_n = 0; rd = 0; ack = 0; step(1);
    chk("R1", 4'b0000);
    rst_n = 1; step(6); chk("R1", 4'b0000);
  endtask

  initial begin
    step(1);
    t_reset();
    t_read();
    t_write();
    t_interlock();
    t_conflict();
    t_early();
    t_reset_mid();
    t_read();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule